// File: doc/BRIEF.md
# Burst-Addressed Pipelined Memory Port

This block is one synchronous port onto a word-organised RAM whose words are split into 9-bit byte lanes. The port does not need a new address every cycle. An internal address register sets the location of each access. In any cycle that register can be cleared to zero, loaded from the address pins, stepped up by one, or left as it is. A host can therefore stream a run of consecutive words after giving only the first address. It can also give a fresh address on every clock for random access.

Writes are masked per lane. Reads pass through two register stages: the memory's own output register and an output pipeline register. A read's data therefore arrives two clock edges after the read cycle. The pins that would be tri-stated on a physical part are represented by a `dout_valid` flag. This flag depends on whether a selected read took place two cycles back and on the output enable seen in the cycle after that read. The target configuration is 16K words of 36 bits, which is `ADDR_W = 14`. The default elaborates a smaller 1K-word array with the same behaviour.

Top module: `sram_burst_port`

## Requirements
- R1: After reset, `dout` is zero, `dout_valid` is 0 and the internal address is 0, so a first access with no clear, load or step goes to word 0.
- R2: With `clr_n` high and `ld_n` low, the access in that cycle uses `addr`, and the internal address takes that value at the rising edge. A new address may be given on every cycle.
- R3: With `clr_n` and `ld_n` high and `adv_n` low, the access uses the internal address plus one, and the internal address keeps that value.
- R4: With `clr_n`, `ld_n` and `adv_n` all high, the internal address is unchanged. Repeated reads then return the same word.
- R5: The controls have a fixed priority: `clr_n` low (address 0) comes first, then `ld_n` low, then `adv_n` low.
- R6: The port is selected only when `ce0_n` is 0 and `ce1` is 1. An unselected cycle writes nothing, and its read produces no valid output.
- R7: Read data for the access of cycle N appears on `dout` after the rising edge that ends cycle N+1, not earlier.
- R8: A write (`rd_wr` = 0) stores lane i, which is `din[9i+8:9i]`, only when `be_n[i]` is 0. A write with `be_n` = 4'b1111 leaves the word unchanged.
- R9: After the edge ending cycle N+1, `dout_valid` is 1 exactly when cycle N was a selected read (`rd_wr` = 1) and `oe_n` was 0 in cycle N+1.
- R10: Stepping from the top address, 2^ADDR_W-1, wraps to address 0.
- R11: `dout` keeps its value when no selected read occurred two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| be_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, takes effect one cycle later |
| ld_n | input | 1 | Load the address pins into the address register, active low |
| adv_n | input | 1 | Step the address register by one, active low |
| clr_n | input | 1 | Clear the address register to zero, active low |
| addr | input | ADDR_W | External word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Pipelined read data |
| dout_valid | output | 1 | Output would be driven (not high impedance) |

## Verification
A write updates the array at the edge that ends its cycle, so it is only observed through a later read. The address register's effect is also observed only through reads, never by probing internals. Each read is checked after the second rising edge following the read cycle. Inputs are driven 1 ns after each edge, and outputs are compared at the same point after the next edge. Burst and hold scenarios check the output on every edge of the stream, so a check one edge early catches the earlier word or a stale valid flag. `dout_valid` is checked with the output enable set differently in the read cycle and in the cycle after it, which separates the one-cycle-late rule from the current-cycle control.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    CTR_HOLD  = 2'd0,
    CTR_STEP  = 2'd1,
    CTR_LOAD  = 2'd2,
    CTR_CLEAR = 2'd3
  } ctr_op_e;

  // Fixed priority: clear, then load, then step, otherwise hold.
  function automatic ctr_op_e pick_ctr_op(input logic clr_n,
                                          input logic ld_n,
                                          input logic adv_n);
    ctr_op_e op;
    if (!clr_n)      op = CTR_CLEAR;
    else if (!ld_n)  op = CTR_LOAD;
    else if (!adv_n) op = CTR_STEP;
    else             op = CTR_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/sbp_rst_sync.sv
module sbp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/sbp_addr_ctr.sv
module sbp_addr_ctr
  import sbp_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctr_op_e       op,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] cur_addr
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic          upd_en;

  // Address used by this cycle's access; it is also the register's next value.
  always_comb begin
    case (op)
      CTR_CLEAR: acc_addr = '0;
      CTR_LOAD:  acc_addr = ext_addr;
      CTR_STEP:  acc_addr = cur_addr + ONE;
      default:   acc_addr = cur_addr;
    endcase
    upd_en = (op != CTR_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_addr <= '0;
    else if (upd_en) cur_addr <= acc_addr;
  end

endmodule

// File: rtl/sbp_lane_ram.sv
module sbp_lane_ram #(
  parameter int AW = 10,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  // First read stage: registered array output, loaded only on a read.
  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[addr];
  end

endmodule

// File: rtl/sbp_rd_pipe.sv
module sbp_rd_pipe #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic          oe_n,
  input  logic [DW-1:0] raw_data,
  output logic [DW-1:0] dout,
  output logic          dout_valid
);

  logic          rd_s1_q;
  logic [DW-1:0] dout_d;
  logic          valid_d;

  always_comb begin
    dout_d  = rd_s1_q ? raw_data : dout;
    valid_d = rd_s1_q & ~oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_s1_q    <= 1'b0;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      rd_s1_q    <= rd_issue;
      dout       <= dout_d;
      dout_valid <= valid_d;
    end
  end

endmodule

// File: rtl/sram_burst_port.sv
module sram_burst_port
  import sbp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce0_n,
  input  logic                      ce1,
  input  logic                      rd_wr,
  input  logic [LANES-1:0]          be_n,
  input  logic                      oe_n,
  input  logic                      ld_n,
  input  logic                      adv_n,
  input  logic                      clr_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_valid
);

  localparam int DATA_W = LANES * LANE_W;

  logic              rst_sync_n;
  logic              sel;
  logic              rd_issue;
  logic              wr_issue;
  ctr_op_e           ctr_op;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] raw_data;

  always_comb begin
    sel      = ~ce0_n & ce1;
    rd_issue = sel & rd_wr;
    wr_issue = sel & ~rd_wr;
    ctr_op   = pick_ctr_op(clr_n, ld_n, adv_n);
  end

  sbp_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sbp_addr_ctr #(.AW(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (ctr_op),
    .ext_addr (addr),
    .acc_addr (acc_addr),
    .cur_addr (cur_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbp_lane_ram #(.AW(ADDR_W), .W(LANE_W)) u_ram (
      .clk   (clk),
      .wr_en (wr_issue & ~be_n[g]),
      .rd_en (rd_issue),
      .addr  (acc_addr),
      .wdata (din[g*LANE_W +: LANE_W]),
      .rdata (raw_data[g*LANE_W +: LANE_W])
    );
  end

  sbp_rd_pipe #(.DW(DATA_W)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_issue   (rd_issue),
    .oe_n       (oe_n),
    .raw_data   (raw_data),
    .dout       (dout),
    .dout_valid (dout_valid)
  );

endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce0_n,
  input logic          ce1,
  input logic          rd_wr,
  input logic          oe_n,
  input logic          ld_n,
  input logic          adv_n,
  input logic          clr_n,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] cur_addr,
  input logic [DW-1:0] dout,
  input logic          dout_valid
);

  // R5: clear wins over everything
  a_r5_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> cur_addr == '0);

  // R2: load takes the pin address
  a_r2_load_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> cur_addr == $past(addr));

  // R3 / R10: step adds one, wrapping at the top
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !adv_n) |=> cur_addr == AW'($past(cur_addr) + 1'b1));

  // R4: no strobe keeps the address
  a_r4_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && adv_n) |=> $stable(cur_addr));

  // R9: valid output needs a selected read two back and oe_n low one back
  a_r9_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (!$past(oe_n) && $past(!ce0_n && ce1 && rd_wr, 2)));

  // R11: no read two cycles back leaves dout unchanged
  a_r11_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!(!ce0_n && ce1 && rd_wr), 2)) |-> $stable(dout));

endmodule

bind sram_burst_port sbp_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ce0_n      (ce0_n),
  .ce1        (ce1),
  .rd_wr      (rd_wr),
  .oe_n       (oe_n),
  .ld_n       (ld_n),
  .adv_n      (adv_n),
  .clr_n      (clr_n),
  .addr       (addr),
  .cur_addr   (cur_addr),
  .dout       (dout),
  .dout_valid (dout_valid)
);

// File: tb/tb_sram_burst_port.sv
`timescale 1ns/1ps
module tb_sram_burst_port;

  localparam int AW  = 10;
  localparam int DW  = 36;
  localparam logic [AW-1:0] TOP = AW'((1 << AW) - 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce0_n, ce1, rd_wr, oe_n, ld_n, adv_n, clr_n;
  logic [3:0]    be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sram_burst_port #(.ADDR_W(AW), .LANE_W(9), .LANES(4)) dut (
    .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .rd_wr(rd_wr),
    .be_n(be_n), .oe_n(oe_n), .ld_n(ld_n), .adv_n(adv_n), .clr_n(clr_n),
    .addr(addr), .din(din), .dout(dout), .dout_valid(dout_valid)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of controls, then advance to 1 ns after the next edge.
  task automatic drv(input logic c0n, input logic c1, input logic rd, input logic [3:0] ben,
                     input logic oen, input logic ldn, input logic advn, input logic clrn,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0_n = c0n; ce1 = c1; rd_wr = rd; be_n = ben; oe_n = oen;
    ld_n = ldn; adv_n = advn; clr_n = clrn; addr = a; din = d;
    @(posedge clk); #1;
  endtask

  task automatic idle(input logic oen);
    drv(1'b1, 1'b0, 1'b1, 4'hF, oen, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic write_at(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] ben);
    drv(1'b0, 1'b1, 1'b0, ben, 1'b0, 1'b0, 1'b1, 1'b1, a, d);
  endtask

  task automatic read_at(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, a, '0);
    idle(1'b0);
    chk({tag, " data"}, dout, exp);
    chk({tag, " valid"}, {35'd0, dout_valid}, 36'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(1'b0); idle(1'b0);
    rst_n = 1'b1;
    idle(1'b0); idle(1'b0); idle(1'b0);
    chk("R1 dout after reset", dout, '0);
    chk("R1 valid after reset", {35'd0, dout_valid}, '0);
    // no strobe: goes to word 0, pin address ignored
    drv(1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, AW'(5), 36'h1_2345_6789);
    read_at('0, 36'h1_2345_6789, "R1 first access at 0");
  endtask

  task automatic t_random_load;
    write_at(AW'(100), 36'hA_AAAA_0100, 4'h0);
    write_at(AW'(3),   36'h5_5555_0003, 4'h0);
    write_at(AW'(77),  36'h3_3333_0077, 4'h0);
    // back-to-back loaded reads, one new address per clock (R2, R7)
    drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, AW'(77), '0);
    chk("R7 not valid one edge after read", {35'd0, dout_valid}, '0);
    drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, AW'(100), '0);
    chk("R2 load 77", dout, 36'h3_3333_0077);
    drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, AW'(3), '0);
    chk("R2 load 100", dout, 36'hA_AAAA_0100);
    idle(1'b0);
    chk("R2 load 3", dout, 36'h5_5555_0003);
    idle(1'b0);
  endtask

  task automatic t_burst;
    write_at(AW'(5), 36'h0_D000_0005, 4'h0);
    for (int i = 1; i < 4; i++)
      drv(1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, '0, 36'h0_D000_0005 + DW'(i));
    // burst read: load 5 then step three times (R3, R7)
    drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, AW'(5), '0);
    chk("R7 data not early", {35'd0, dout_valid}, '0);
    for (int i = 0; i < 3; i++) begin
      drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, '0, '0);
      chk("R3 burst word", dout, 36'h0_D000_0005 + DW'(i));
    end
    idle(1'b0);
    chk("R3 burst last word", dout, 36'h0_D000_0008);
    idle(1'b0);
    chk("R11 dout kept after idle", dout, 36'h0_D000_0008);
    chk("R11 valid low after idle", {35'd0, dout_valid}, '0);
  endtask

  task automatic t_hold;
    drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, AW'(6), '0);
    for (int i = 0; i < 3; i++) begin
      drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b1, 1'b1, AW'(9), '0);
      chk("R4 held address word", dout, 36'h0_D000_0006);
    end
    idle(1'b0);
    chk("R4 held address last", dout, 36'h0_D000_0006);
    idle(1'b0);
  endtask

  task automatic t_priority;
    write_at(AW'(9), 36'h9_9999_0009, 4'h0);
    write_at(AW'(0), 36'h0_0000_0A0A, 4'h0);
    drv(1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, AW'(9), 36'hC_1EA2_0000);
    read_at('0, 36'hC_1EA2_0000, "R5 clear beats load");
    read_at(AW'(9), 36'h9_9999_0009, "R5 loaded addr untouched");
    write_at(AW'(20), 36'h2_0000_0020, 4'h0);
    write_at(AW'(21), 36'h2_0000_0021, 4'h0);
    drv(1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, AW'(20), 36'hE_EEEE_0020);
    read_at(AW'(20), 36'hE_EEEE_0020, "R5 load beats step");
    read_at(AW'(21), 36'h2_0000_0021, "R5 next word untouched");
  endtask

  task automatic t_select;
    write_at(AW'(30), 36'h3_0303_0303, 4'h0);
    drv(1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, AW'(30), 36'hB_AD00_0001);
    drv(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, AW'(30), 36'hB_AD00_0002);
    read_at(AW'(30), 36'h3_0303_0303, "R6 deselected writes ignored");
    drv(1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, AW'(5), '0);
    idle(1'b0);
    chk("R6 deselected read not valid", {35'd0, dout_valid}, '0);
    chk("R11 dout kept after deselected read", dout, 36'h3_0303_0303);
  endtask

  task automatic t_bytes;
    write_at(AW'(40), {DW{1'b1}}, 4'h0);
    write_at(AW'(40), '0, 4'b1010);
    read_at(AW'(40), {9'h1FF, 9'h000, 9'h1FF, 9'h000}, "R8 lanes 0 and 2 written");
    write_at(AW'(40), '0, 4'hF);
    read_at(AW'(40), {9'h1FF, 9'h000, 9'h1FF, 9'h000}, "R8 all lanes masked");
  endtask

  task automatic t_oe;
    drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1, 1'b1, AW'(30), '0);
    idle(1'b0);
    chk("R9 oe low in following cycle gives valid", {35'd0, dout_valid}, 36'd1);
    chk("R9 data", dout, 36'h3_0303_0303);
    drv(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, AW'(9), '0);
    idle(1'b1);
    chk("R9 oe high in following cycle gives invalid", {35'd0, dout_valid}, '0);
    idle(1'b0);
  endtask

  task automatic t_wrap;
    write_at(TOP, 36'h7_0000_0FFF, 4'h0);
    drv(1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, '0, 36'h7_0000_0000);
    read_at('0, 36'h7_0000_0000, "R10 step wraps to 0");
    read_at(TOP, 36'h7_0000_0FFF, "R10 top word");
  endtask

  initial begin
    t_reset();
    t_random_load();
    t_burst();
    t_hold();
    t_priority();
    t_select();
    t_bytes();
    t_oe();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule